// File: doc/BRIEF.md
# Gate Motor Sequencer

This block steers a motorized gate around a fixed four-phase loop: shut, rising (motor driving the gate open), wide open, and falling (motor driving it shut). Two operator switches request travel, and two limit sensors report when the gate reaches the end of its travel. In each phase the sequencer listens to exactly one of these four inputs and ignores the other three. When the watched input is high at a rising clock edge, the sequencer moves on to the next phase.

The motor commands and the two position indicators depend only on the current phase. A two-bit phase code is also brought out, so that the surrounding logic can see where the loop stands. A synchronous active-high reset returns the gate to the shut phase.

Top module: `gate_seq_top`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the phase after that edge is shut (`phaseCode` = 2'b00), whatever the other inputs are.
- R2: In the shut phase the sequencer stays put while `openReq` is low, even when any of the other three inputs are high. It moves to rising at the first edge where `openReq` is high.
- R3: In the rising phase it stays put while `openStop` is low, and moves to wide open at the first edge where `openStop` is high. The other inputs have no effect.
- R4: In the wide-open phase it stays put while `closeReq` is low, and moves to falling at the first edge where `closeReq` is high. The other inputs have no effect.
- R5: In the falling phase it stays put while `closeStop` is low, and moves back to shut at the first edge where `closeStop` is high. The other inputs have no effect.
- R6: The outputs depend on the phase only. Shut raises only `shutLamp`. Rising raises only `motorFwd`. Wide open raises only `openLamp`. Falling raises only `motorRev`.
- R7: `motorFwd` and `motorRev` are never high together.
- R8: `phaseCode` reads 2'b00 for shut, 2'b01 for rising, 2'b10 for wide open and 2'b11 for falling.
- R9: The sequencer moves at most one phase per clock edge. With all four inputs held high, it steps through shut, rising, wide open and falling and returns to shut on four successive edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces the shut phase |
| openReq | input | 1 | Operator request to open the gate |
| openStop | input | 1 | Limit sensor: gate fully open |
| closeReq | input | 1 | Operator request to close the gate |
| closeStop | input | 1 | Limit sensor: gate fully shut |
| motorFwd | output | 1 | Motor drive in the opening direction |
| motorRev | output | 1 | Motor drive in the closing direction |
| openLamp | output | 1 | Indicator: gate stands open |
| shutLamp | output | 1 | Indicator: gate stands shut |
| phaseCode | output | 2 | Current phase code |

## Verification
Every result is due one rising edge after its stimulus. The phase register is the only storage between the inputs and the outputs, and the outputs are decoded from it without further registers. The bench changes the inputs on falling edges. It lets exactly one rising edge pass and then compares all five outputs on the following falling edge, half a period away from the edge that updated them. For the hold cases it lets several edges pass and checks after each one, so that a single spurious step is caught in the cycle it happens.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  localparam int PhaseBits = 2;

  typedef enum logic [PhaseBits-1:0] {
    PH_SHUT    = 2'b00,
    PH_RISING  = 2'b01,
    PH_WIDE    = 2'b10,
    PH_FALLING = 2'b11
  } gate_phase_e;

  // strobes handed from control to datapath
  typedef struct packed {
    gate_phase_e phase;
    logic        moving;
  } gate_strb_t;

endpackage

// File: rtl/gate_seq_ctrl.sv
module gate_seq_ctrl
  import gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       openReq,
  input  logic       openStop,
  input  logic       closeReq,
  input  logic       closeStop,
  output gate_strb_t strb
);

  gate_phase_e phaseQ;
  gate_phase_e phaseD;
  logic        watched;

  // each phase listens to a single input
  always_comb begin
    case (phaseQ)
      PH_SHUT:    watched = openReq;
      PH_RISING:  watched = openStop;
      PH_WIDE:    watched = closeReq;
      PH_FALLING: watched = closeStop;
      default:    watched = 1'b0;
    endcase
  end

  // the loop order follows the binary count, so advancing is an increment
  always_comb begin
    if (watched) phaseD = gate_phase_e'(phaseQ + 2'b01);
    else         phaseD = phaseQ;
  end

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PH_SHUT;
    else     phaseQ <= phaseD;
  end

  always_comb begin
    strb.phase  = phaseQ;
    strb.moving = phaseQ[0];
  end

endmodule

// File: rtl/gate_seq_dp.sv
module gate_seq_dp
  import gate_seq_pkg::*;
(
  input  gate_strb_t             strb,
  output logic                   motorFwd,
  output logic                   motorRev,
  output logic                   openLamp,
  output logic                   shutLamp,
  output logic [PhaseBits-1:0]   phaseCode
);

  always_comb begin
    motorFwd = 1'b0;
    motorRev = 1'b0;
    openLamp = 1'b0;
    shutLamp = 1'b0;
    if (strb.moving) begin
      if (strb.phase == PH_RISING) motorFwd = 1'b1;
      else                         motorRev = 1'b1;
    end else begin
      if (strb.phase == PH_WIDE) openLamp = 1'b1;
      else                       shutLamp = 1'b1;
    end
    phaseCode = strb.phase;
  end

endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       openReq,
  input  logic       openStop,
  input  logic       closeReq,
  input  logic       closeStop,
  output logic       motorFwd,
  output logic       motorRev,
  output logic       openLamp,
  output logic       shutLamp,
  output logic [1:0] phaseCode
);

  gate_strb_t strb;

  gate_seq_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .openReq   (openReq),
    .openStop  (openStop),
    .closeReq  (closeReq),
    .closeStop (closeStop),
    .strb      (strb)
  );

  gate_seq_dp dp_i (
    .strb      (strb),
    .motorFwd  (motorFwd),
    .motorRev  (motorRev),
    .openLamp  (openLamp),
    .shutLamp  (shutLamp),
    .phaseCode (phaseCode)
  );

endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       openReq,
  input logic       openStop,
  input logic       closeReq,
  input logic       closeStop,
  input logic       motorFwd,
  input logic       motorRev,
  input logic       openLamp,
  input logic       shutLamp,
  input logic [1:0] phaseCode
);

  p_reset_shut_r1: assert property (@(posedge clk) rst |=> (phaseCode == 2'b00));

  p_hold_shut_r2: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b00 && !openReq) |=> (phaseCode == 2'b00));
  p_go_rising_r2: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b00 && openReq) |=> (phaseCode == 2'b01));

  p_hold_rising_r3: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b01 && !openStop) |=> (phaseCode == 2'b01));
  p_go_wide_r3: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b01 && openStop) |=> (phaseCode == 2'b10));

  p_hold_wide_r4: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b10 && !closeReq) |=> (phaseCode == 2'b10));
  p_go_falling_r4: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b10 && closeReq) |=> (phaseCode == 2'b11));

  p_hold_falling_r5: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b11 && !closeStop) |=> (phaseCode == 2'b11));
  p_go_shut_r5: assert property (@(posedge clk) disable iff (rst)
    (phaseCode == 2'b11 && closeStop) |=> (phaseCode == 2'b00));

  p_one_output_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot({motorFwd, motorRev, openLamp, shutLamp}));
  p_fwd_phase_r6: assert property (@(posedge clk) disable iff (rst)
    motorFwd |-> (phaseCode == 2'b01));

  p_no_both_motor_r7: assert property (@(posedge clk) disable iff (rst)
    !(motorFwd && motorRev));

endmodule

bind gate_seq_top gate_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .openReq   (openReq),
  .openStop  (openStop),
  .closeReq  (closeReq),
  .closeStop (closeStop),
  .motorFwd  (motorFwd),
  .motorRev  (motorRev),
  .openLamp  (openLamp),
  .shutLamp  (shutLamp),
  .phaseCode (phaseCode)
);

// File: tb/gate_seq_top_tb_top.sv
module gate_seq_top_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic openReq = 1'b0, openStop = 1'b0, closeReq = 1'b0, closeStop = 1'b0;
  logic motorFwd, motorRev, openLamp, shutLamp;
  logic [1:0] phaseCode;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  gate_seq_top dut_i (
    .clk(clk), .rst(rst),
    .openReq(openReq), .openStop(openStop),
    .closeReq(closeReq), .closeStop(closeStop),
    .motorFwd(motorFwd), .motorRev(motorRev),
    .openLamp(openLamp), .shutLamp(shutLamp),
    .phaseCode(phaseCode)
  );

  // expected {phaseCode, motorFwd, motorRev, openLamp, shutLamp} (R6, R8)
  function automatic logic [5:0] expect_of(input logic [1:0] ph);
    case (ph)
      2'b00:   return {2'b00, 4'b0001};
      2'b01:   return {2'b01, 4'b1000};
      2'b10:   return {2'b10, 4'b0010};
      default: return {2'b11, 4'b0100};
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] ph);
    logic [5:0] act, exp;
    act = {phaseCode, motorFwd, motorRev, openLamp, shutLamp};
    exp = expect_of(ph);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input logic [3:0] v);
    {openReq, openStop, closeReq, closeStop} = v;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    set_in(4'b0000);
    step();
    rst = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    check("R1 reset phase", 2'b00);
  endtask

  // R2: shut ignores everything but openReq
  task automatic t_shut();
    do_reset();
    set_in(4'b0111);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R2 shut holds", 2'b00);
    end
    set_in(4'b1000);
    step();
    check("R2 shut to rising", 2'b01);
  endtask

  // R3: rising waits on openStop
  task automatic t_rising();
    set_in(4'b1011);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R3 rising holds", 2'b01);
    end
    set_in(4'b0100);
    step();
    check("R3 rising to wide", 2'b10);
  endtask

  // R4: wide waits on closeReq
  task automatic t_wide();
    set_in(4'b1101);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R4 wide holds", 2'b10);
    end
    set_in(4'b0010);
    step();
    check("R4 wide to falling", 2'b11);
  endtask

  // R5, R7: falling waits on closeStop, wraps to shut
  task automatic t_falling();
    set_in(4'b1110);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R5 R7 falling holds", 2'b11);
    end
    set_in(4'b0001);
    step();
    check("R5 falling to shut", 2'b00);
  endtask

  // R9: all inputs high advance exactly one phase per edge
  task automatic t_all_high();
    do_reset();
    set_in(4'b1111);
    for (int i = 1; i <= 8; i++) begin
      step();
      check("R9 one step per edge", 2'(i));
    end
  endtask

  // R1: reset wins from a mid-loop phase with inputs active
  task automatic t_reset_mid();
    do_reset();
    set_in(4'b1100);
    step();
    step();
    check("R8 wide code", 2'b10);
    rst = 1'b1;
    set_in(4'b1111);
    step();
    check("R1 reset from wide", 2'b00);
    rst = 1'b0;
    set_in(4'b0000);
    step();
    check("R1 stays shut after reset", 2'b00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_shut();
    t_rising();
    t_wide();
    t_falling();
    t_all_high();
    t_reset_mid();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule